// File: doc/BRIEF.md
# Dual Wiper Register Instruction Executor

This block is the command core of a two-channel digital potentiometer controller. It sits behind a serial front end that has already found the frame boundaries and the byte values. The front end hands over one-cycle strobes for an instruction byte, for a data byte and for the end-of-frame (STOP) condition, together with a write-enable level. The block keeps two volatile 6-bit wiper positions and eight 6-bit data registers, four for each pot. The data registers stand in for non-volatile storage, so they keep their contents across the synchronous reset.

The block decodes the instruction byte and carries out the selected action. It can read a wiper or a data register, write a wiper or a data register, or transfer a value between a wiper and one of its data registers. It can also transfer between both pots at once (gang), or step a wiper by one tap at a time.

Reads answer straight away. Every change to the registers waits for STOP. A change to a data register starts a simulated program cycle that lasts a set number of clocks. During that cycle the block ignores all strobes. The cycle can be cancelled before it starts by taking the write-enable level low at any time between the instruction byte and STOP.

Top module: `dual_wiper_exec`

## Requirements
- R1: While `rst_n` is low at a clock edge, wiper 0 loads data register index 0 and wiper 1 loads data register index 4. The data registers keep their contents across reset. At power-up their contents come from the `DR_INIT` parameter, with register index i held in bits 6i+5:6i.
- R2: The instruction byte layout is fixed:
  - bits 7:4 hold the opcode;
  - bits 3:2 hold the register select r;
  - bit 0 holds the pot select p;
  - the data register index is 4p+r.

  An instruction with bit 1 set, or with an opcode outside the nine defined ones, is ignored. Its data strobes and its STOP then change nothing.
- R3: Opcode 1001 reads wiper p and opcode 1011 reads data register 4p+r. The value appears on `rd_byte` in the cycle after the instruction strobe, with bits 7:6 equal to zero.
- R4: Opcode 1010 (write wiper p with the last data byte) and opcode 1101 (copy data register 4p+r into wiper p) take effect at STOP. Bits 7:6 of the data byte are discarded. A 1010 frame with no data byte before STOP changes nothing.
- R5: Opcode 1100 (write data register 4p+r with the data byte) and opcode 1110 (copy wiper p into data register 4p+r) take effect at STOP. `busy` is then high for exactly `PROG_CYCLES` cycles, starting in the cycle after the STOP strobe.
- R6: Opcode 0001 copies data register r into wiper 0 and data register 4+r into wiper 1. Opcode 1000 copies wiper 0 into register r and wiper 1 into register 4+r, with a program cycle as in R5. The pot bit is ignored for both.
- R7: If `wp` is low at STOP, or at any cycle since the instruction strobe, a data register change is cancelled: no register changes and `busy` stays low. Wiper changes go ahead whatever the level of `wp`.
- R8: Taking `wp` low while `busy` is high does not affect the data already committed.
- R9: While `busy` is high, instruction, data and STOP strobes are ignored.
- R10: After opcode 0010, each data strobe moves wiper p by one tap at once. It moves up when `data_byte[0]` is 1 and down when it is 0, and it holds at 63 and at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_stb | input | 1 | One-cycle strobe: `instr_byte` is valid |
| instr_byte | input | 8 | Instruction byte |
| data_stb | input | 1 | One-cycle strobe: `data_byte` is valid |
| data_byte | input | 8 | Data byte, or step direction in bit 0 |
| stop_stb | input | 1 | One-cycle strobe marking end of frame |
| wp | input | 1 | High permits data register changes |
| rd_byte | output | 8 | Read result |
| wiper0 | output | 6 | Wiper position of pot 0 |
| wiper1 | output | 6 | Wiper position of pot 1 |
| busy | output | 1 | Program cycle in progress |

## Verification
The assertions take for granted that each strobe lasts one cycle and that no two strobes arrive in the same cycle. They also assume that a frame opens with an instruction strobe before any data or STOP. The step ceiling check further assumes the step direction bit is valid whenever a data strobe arrives. The bench drives every strobe from tasks that raise exactly one strobe for a single cycle. Its random transactions always follow the order instruction, optional data or steps, then STOP, with a `wp` dip placed only between the instruction and STOP.

// File: rtl/dual_wiper_exec.sv
module dual_wiper_exec #(
  parameter int          PROG_CYCLES = 250000,
  parameter logic [47:0] DR_INIT     = 48'h0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       instr_stb,
  input  logic [7:0] instr_byte,
  input  logic       data_stb,
  input  logic [7:0] data_byte,
  input  logic       stop_stb,
  input  logic       wp,
  output logic [7:0] rd_byte,
  output logic [5:0] wiper0,
  output logic [5:0] wiper1,
  output logic       busy
);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  localparam logic [3:0] OP_GD2W = 4'h1, OP_STEP = 4'h2, OP_GW2D = 4'h8,
                         OP_RD_W = 4'h9, OP_WR_W = 4'hA, OP_RD_DR = 4'hB,
                         OP_WR_DR = 4'hC, OP_D2W = 4'hD, OP_W2D = 4'hE;

  logic [47:0]   dr_flat = DR_INIT;
  logic [5:0]    wip [2];
  logic [3:0]    op_q;
  logic [1:0]    rs_q;
  logic          pot_q, have_op, have_data, wp_drop;
  logic [5:0]    dat_q;
  logic [CW-1:0] cnt;
  logic          unused_hi;

  assign unused_hi = ^data_byte[7:6];
  assign busy   = (cnt != '0);
  assign wiper0 = wip[0];
  assign wiper1 = wip[1];

  wire       idle  = !busy;
  wire [3:0] iop   = instr_byte[7:4];
  wire       known = !instr_byte[1] && (iop inside {OP_GD2W, OP_STEP, OP_GW2D, OP_RD_W,
                       OP_WR_W, OP_RD_DR, OP_WR_DR, OP_D2W, OP_W2D});
  wire [2:0] sel   = {pot_q, rs_q};
  wire [2:0] sel0  = {1'b0, rs_q};
  wire [2:0] sel1  = {1'b1, rs_q};
  wire [2:0] isel  = {instr_byte[0], instr_byte[3:2]};
  wire       nv_ok = wp && !wp_drop;
  wire       go    = stop_stb && idle && have_op;
  wire       nv_go = go && nv_ok && ((op_q == OP_WR_DR && have_data) ||
                                     op_q == OP_W2D || op_q == OP_GW2D);
  wire       step  = data_stb && idle && have_op && op_q == OP_STEP;

  always_ff @(posedge clk) begin
    if (nv_go) begin
      case (op_q)
        OP_WR_DR: dr_flat[6*int'(sel) +: 6] <= dat_q;
        OP_W2D:   dr_flat[6*int'(sel) +: 6] <= wip[pot_q];
        default: begin
          dr_flat[6*int'(sel0) +: 6] <= wip[0];
          dr_flat[6*int'(sel1) +: 6] <= wip[1];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wip[0] <= dr_flat[5:0];
      wip[1] <= dr_flat[29:24];
    end else if (go) begin
      case (op_q)
        OP_WR_W: if (have_data) wip[pot_q] <= dat_q;
        OP_D2W:  wip[pot_q] <= dr_flat[6*int'(sel) +: 6];
        OP_GD2W: begin
          wip[0] <= dr_flat[6*int'(sel0) +: 6];
          wip[1] <= dr_flat[6*int'(sel1) +: 6];
        end
        default: ;
      endcase
    end else if (step) begin
      if (data_byte[0] && wip[pot_q] != 6'h3F) wip[pot_q] <= wip[pot_q] + 6'd1;
      else if (!data_byte[0] && wip[pot_q] != 6'h00) wip[pot_q] <= wip[pot_q] - 6'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q <= '0; rs_q <= '0; pot_q <= 1'b0; dat_q <= '0;
      have_op <= 1'b0; have_data <= 1'b0; wp_drop <= 1'b0;
      rd_byte <= '0; cnt <= '0;
    end else begin
      if (instr_stb && idle) wp_drop <= !wp;
      else if (!wp)          wp_drop <= 1'b1;

      if (instr_stb && idle) begin
        op_q <= iop; rs_q <= instr_byte[3:2]; pot_q <= instr_byte[0];
        have_op <= known; have_data <= 1'b0;
        if (known && iop == OP_RD_W)  rd_byte <= {2'b00, wip[instr_byte[0]]};
        if (known && iop == OP_RD_DR) rd_byte <= {2'b00, dr_flat[6*int'(isel) +: 6]};
      end else if (data_stb && idle && have_op) begin
        dat_q <= data_byte[5:0];
        have_data <= 1'b1;
      end
      if (go) begin
        have_op <= 1'b0;
        have_data <= 1'b0;
      end

      if (nv_go)     cnt <= CW'(PROG_CYCLES);
      else if (busy) cnt <= cnt - 1'b1;
    end
  end

  assert_prot_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_stb && idle && !wp) |=> ($stable(dr_flat) && !busy));

  assert_busy_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_stb));

  assert_quiet_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(wiper0) && $stable(wiper1) && $stable(dr_flat)));

  assert_step_ceiling_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !pot_q && data_byte[0] && wiper0 == 6'h3F) |=> (wiper0 == 6'h3F));

  assert_step_floor_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && pot_q && !data_byte[0] && wiper1 == 6'h00) |=> (wiper1 == 6'h00));
endmodule

// File: tb/tb_dual_wiper_exec.sv
module tb_dual_wiper_exec;
  localparam int PROG = 20;
  localparam logic [47:0] INIT = {6'h22, 6'h00, 6'h30, 6'h07, 6'h01, 6'h3F, 6'h2A, 6'h15};

  logic clk = 0, rst_n = 0, instr_stb = 0, data_stb = 0, stop_stb = 0, wp = 1;
  logic [7:0] instr_byte = 0, data_byte = 0;
  logic [7:0] rd_byte;
  logic [5:0] wiper0, wiper1;
  logic busy;

  dual_wiper_exec #(.PROG_CYCLES(PROG), .DR_INIT(INIT)) dut (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [5:0] m_w [2];
  logic [5:0] m_dr [8];

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic p_instr(logic [7:0] b); instr_byte = b; instr_stb = 1; tick(); instr_stb = 0; endtask
  task automatic p_data(logic [7:0] b); data_byte = b; data_stb = 1; tick(); data_stb = 0; endtask
  task automatic p_stop(); stop_stb = 1; tick(); stop_stb = 0; endtask

  function automatic logic [5:0] sat_step(logic [5:0] v, logic up);
    if (up) return (v == 6'h3F) ? v : v + 6'd1;
    return (v == 6'h00) ? v : v - 6'd1;
  endfunction

  task automatic check_wipers(string tag);
    chk({tag, " wiper0"}, wiper0, m_w[0]);
    chk({tag, " wiper1"}, wiper1, m_w[1]);
  endtask

  task automatic wait_prog(string tag);
    chk({tag, " busy start"}, busy, 1);
    repeat (PROG - 1) tick();
    chk({tag, " busy last"}, busy, 1);
    tick();
    chk({tag, " busy end"}, busy, 0);
  endtask

  task automatic read_dr(int idx, string tag);
    p_instr({4'hB, 2'(idx % 4), 1'b0, 1'(idx / 4)});
    chk({tag, " rd_byte"}, rd_byte, {2'b00, m_dr[idx]});
    p_stop();
  endtask

  task automatic do_reset();
    rst_n = 0; repeat (3) tick(); rst_n = 1; tick();
    m_w[0] = m_dr[0]; m_w[1] = m_dr[4];
  endtask

  task automatic txn(logic [3:0] op, logic [1:0] r, logic p, logic [7:0] d,
                     bit glitch, int nsteps, string tag);
    bit nv, nvw;
    int ix;
    ix = int'(p) * 4 + int'(r);
    nv = wp && !glitch;
    nvw = 0;
    p_instr({op, r, 1'b0, p});
    if (op == 4'h9) chk({tag, " R3 read wiper"}, rd_byte, {2'b00, m_w[p]});
    if (op == 4'hB) chk({tag, " R3 read dr"}, rd_byte, {2'b00, m_dr[ix]});
    if (op == 4'hA || op == 4'hC) p_data(d);
    if (op == 4'h2) begin
      for (int k = 0; k < nsteps; k++) begin
        logic up;
        up = 1'($urandom_range(0, 1));
        p_data({7'd0, up});
        m_w[p] = sat_step(m_w[p], up);
        check_wipers({tag, " R10 step"});
      end
    end
    if (glitch) begin wp = 0; tick(); wp = 1; end
    p_stop();
    case (op)
      4'hA: m_w[p] = d[5:0];
      4'hD: m_w[p] = m_dr[ix];
      4'h1: begin m_w[0] = m_dr[r]; m_w[1] = m_dr[4 + r]; end
      4'hC: if (nv) begin m_dr[ix] = d[5:0]; nvw = 1; end
      4'hE: if (nv) begin m_dr[ix] = m_w[p]; nvw = 1; end
      4'h8: if (nv) begin m_dr[r] = m_w[0]; m_dr[4 + r] = m_w[1]; nvw = 1; end
      default: ;
    endcase
    check_wipers({tag, " R4 R6 wipers"});
    if (nvw) wait_prog({tag, " R5"});
    else chk({tag, " R7 no busy"}, busy, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) m_dr[i] = INIT[6*i +: 6];
    tick();
    do_reset();
    chk("R1 reset wiper0", wiper0, 6'h15);
    chk("R1 reset wiper1", wiper1, 6'h07);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset rd_byte", rd_byte, 0);

    for (int i = 0; i < 8; i++) read_dr(i, "R3 initial");
    txn(4'h9, 2'd0, 1'b1, 8'h00, 0, 0, "R3 rdw");

    txn(4'hA, 2'd0, 1'b1, 8'hFF, 0, 0, "R4 wr wiper1 top bits");
    chk("R4 wiper1 = 3F", wiper1, 6'h3F);
    p_instr(8'hA0); p_stop();
    check_wipers("R4 no data no change");
    txn(4'hD, 2'd3, 1'b0, 8'h00, 0, 0, "R4 d2w");

    txn(4'hC, 2'd2, 1'b0, 8'hCC, 0, 0, "R5 wr dr2");
    read_dr(2, "R5 readback");
    txn(4'hE, 2'd1, 1'b1, 8'h00, 0, 0, "R5 w2d");
    read_dr(5, "R5 w2d readback");

    txn(4'h1, 2'd1, 1'b0, 8'h00, 0, 0, "R6 gang d2w");
    txn(4'hA, 2'd0, 1'b0, 8'h11, 0, 0, "R6 prep");
    txn(4'h8, 2'd3, 1'b1, 8'h00, 0, 0, "R6 gang w2d");
    read_dr(3, "R6 gang dr3"); read_dr(7, "R6 gang dr7");

    wp = 0;
    txn(4'hC, 2'd0, 1'b1, 8'h2D, 0, 0, "R7 wp low dr");
    txn(4'hA, 2'd0, 1'b1, 8'h2D, 0, 0, "R7 wp low wiper ok");
    wp = 1;
    read_dr(4, "R7 dr unchanged");
    txn(4'hE, 2'd1, 1'b0, 8'h00, 1, 0, "R7 wp dip");
    read_dr(1, "R7 dip dr unchanged");

    p_instr({4'hC, 2'd1, 1'b0, 1'b1}); p_data(8'h19); p_stop();
    m_dr[5] = 6'h19;
    wp = 0;
    wait_prog("R8 wp low in cycle");
    wp = 1;
    read_dr(5, "R8 kept");

    p_instr({4'hC, 2'd2, 1'b0, 1'b1}); p_data(8'h0E); p_stop();
    m_dr[6] = 6'h0E;
    p_instr(8'hA0); p_data(8'h01); p_stop();
    p_instr(8'h90);
    for (int k = 0; k < 2 * PROG && busy; k++) tick();
    chk("R9 busy done", busy, 0);
    check_wipers("R9 ignored while busy");
    read_dr(6, "R9 dr");

    txn(4'hA, 2'd0, 1'b0, 8'h3E, 0, 0, "R10 prep");
    p_instr(8'h20);
    p_data(8'h01); p_data(8'h01); p_data(8'h01);
    p_stop();
    m_w[0] = 6'h3F;
    chk("R10 ceiling", wiper0, 6'h3F);
    txn(4'hA, 2'd0, 1'b1, 8'h01, 0, 0, "R10 prep2");
    p_instr(8'h21);
    p_data(8'h00); p_data(8'h00); p_data(8'hFE);
    p_stop();
    m_w[1] = 6'h00;
    chk("R10 floor", wiper1, 6'h00);

    p_instr(8'h50); p_data(8'h05); p_stop();
    p_instr(8'hA2); p_data(8'h05); p_stop();
    p_instr(8'hC2); p_data(8'h05); p_stop();
    check_wipers("R2 ignored");
    chk("R2 no busy", busy, 0);
    read_dr(0, "R2 dr0 intact");

    txn(4'hC, 2'd0, 1'b0, 8'h2B, 0, 0, "R1 prep dr0");
    txn(4'hC, 2'd0, 1'b1, 8'h31, 0, 0, "R1 prep dr4");
    txn(4'hA, 2'd0, 1'b0, 8'h00, 0, 0, "R1 prep w0");
    do_reset();
    chk("R1 reload wiper0", wiper0, 6'h2B);
    chk("R1 reload wiper1", wiper1, 6'h31);

    for (int t = 0; t < 300; t++) begin
      logic [3:0] ops [12];
      logic [3:0] op;
      ops = '{4'h1, 4'h2, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD, 4'hE, 4'h0, 4'hF, 4'h3};
      op = ops[$urandom_range(0, 11)];
      txn(op, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 8'($urandom()),
          ($urandom_range(0, 6) == 0), $urandom_range(1, 5), "R2 R3 R4 R5 R6 R7 random");
      if (t % 50 == 49) for (int i = 0; i < 8; i++) read_dr(i, "R5 R6 random dr");
    end

    finish_up();
  end
endmodule